// File: doc/BRIEF.md
# Paged Host Register Bank

This block is the host-visible register file of an audio interface device. A simple synchronous host port carries a 7-bit byte address, write data, a write strobe, a read strobe and registered read data. The 128-address window is multiplexed over four pages. A page register at the top address of the window (0x7F) chooses the page, and that register can be reached from every page.

Page 0 holds general control bytes. Page 1 is a receive buffer of channel-status and user bytes. The device side fills it as a whole block with one strobe, and the host can only read it. Page 2 is a transmit buffer of channel-status and user bytes. The host writes it and can read it back, and the device side reads it through its own combinational read port. Page 3 is a test page. It stays dark until the host writes a two-byte key sequence to a key address on page 0.

Top module: `paged_regbank`

## Requirements
- R1: A host write to address 0x7F on any page loads the page register with write-data bits [1:0]. A read of 0x7F on any page returns the page number zero-extended, including while page 3 is selected and locked. Page numbers: 0 control, 1 receive buffer, 2 transmit buffer, 3 test.
- R2: After reset the page register is 0, the test page is locked, and every stored byte reads 0x00.
- R3: Read data appears on the output one clock after the read strobe and holds until the next read. A read and a write to the same byte in the same cycle return the old value.
- R4: On page 0, addresses 0x01 to 0x33 are read/write control bytes. Address 0x00 and addresses 0x34 to 0x7E read 0x00, and host writes to them change no readable byte.
- R5: On page 1, the host reads receive byte i at address i (0 to 47: channel-status bytes 0 to 23, then user bytes 24 to 47). Host writes to page 1 change nothing.
- R6: The receive buffer changes only in a cycle where the device load strobe is high, and then all 48 bytes take the device input at once, with byte i taken from bits [8i+7:8i].
- R7: On page 2, addresses 0 to 47 are host read/write transmit bytes. The device read port returns transmit byte i in the same cycle its index is presented.
- R8: The test page unlocks after two consecutive host writes to address 0x7E on page 0, of 0xA5 and then 0x5A. Any other write, including a second 0xA5, discards the progress. Once unlocked, the page stays unlocked until reset.
- R9: While locked, page 3 reads 0x00 at every address except 0x7F and ignores writes. Once unlocked, addresses 0x00 to 0x03 on page 3 are read/write test bytes.
- R10: On pages 1, 2 and 3, addresses beyond the mapped bytes (other than 0x7F) read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 7 | Host byte address within the current page |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered host read data |
| dev_rx_load | input | 1 | Device strobe that loads the whole receive block |
| dev_rx_bytes | input | 384 | Receive block, byte i in bits [8i+7:8i] |
| dev_tx_idx | input | 6 | Device-side transmit byte index |
| dev_tx_byte | output | 8 | Transmit byte at dev_tx_idx |

## Verification
A corrupted page register shows on the very next read of 0x7F. It also shows on the next access to a mapped byte, which then reads from the wrong store. An unlock state machine that opens early or late shows one cycle after the first page-3 read, which returns test data where zero was due, or zero where data was due. A receive buffer that is touched outside a load strobe shows on the next page-1 read. A transmit byte that is stored wrongly shows at once on the device read port, because that port is compared on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int ADDR_W = 7;
   localparam int DATA_W = 8;
   localparam logic [ADDR_W-1:0] SEL_ADDR = 7'h7F;
   localparam logic [ADDR_W-1:0] KEY_ADDR = 7'h7E;

   typedef enum logic [1:0] {
      PG_CTRL = 2'd0,
      PG_RX   = 2'd1,
      PG_TX   = 2'd2,
      PG_TEST = 2'd3
   } page_e;

   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_FIRST = 2'd1,
      LK_OPEN  = 2'd2
   } lock_e;
endpackage

// File: rtl/regbank_unlock.sv
module regbank_unlock
   import regbank_pkg::*;
#(
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_wr,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              unlocked_o
);
   lock_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (any_wr && state_q != LK_OPEN) begin
         if (key_wr && state_q == LK_IDLE && wdata == KEY_FIRST)
            state_d = LK_FIRST;
         else if (key_wr && state_q == LK_FIRST && wdata == KEY_SECOND)
            state_d = LK_OPEN;
         else
            state_d = LK_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LK_IDLE;
      else        state_q <= state_d;
   end

   assign unlocked_o = (state_q == LK_OPEN);

   // R8: once open, stays open
   assert_unlock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked_o |=> unlocked_o);

   // R8: opening only follows a key write carrying the second key byte
   assert_unlock_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked_o ##1 unlocked_o) |-> $past(key_wr && wdata == KEY_SECOND));
endmodule

// File: rtl/regbank_store.sv
module regbank_store
   import regbank_pkg::*;
#(
   parameter int N        = 4,
   parameter bit HOST_WR  = 1'b1,
   parameter bit DEV_LOAD = 1'b0,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_en,
   input  logic [N*DATA_W-1:0] load_bytes,
   output logic [N*DATA_W-1:0] bytes_o
);
   if (N < 1) begin : g_bad_n
      $error("regbank_store: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_byte
      logic [DATA_W-1:0] b_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            b_q <= '0;
         else if (DEV_LOAD && load_en)
            b_q <= load_bytes[i*DATA_W +: DATA_W];
         else if (HOST_WR && wr_en && wr_idx == IW'(i))
            b_q <= wr_data;
      end
      assign bytes_o[i*DATA_W +: DATA_W] = b_q;
   end

   if (DEV_LOAD && !HOST_WR) begin : g_rx_chk
      // R6: a device-loaded, host-read-only buffer moves only on the load strobe
      assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !load_en |=> $stable(bytes_o));
   end
endmodule

// File: rtl/paged_regbank.sv
module paged_regbank
   import regbank_pkg::*;
#(
   parameter int CS_BYTES   = 24,
   parameter int USR_BYTES  = 24,
   parameter int CTRL_LAST  = 8'h33,
   parameter int TEST_BYTES = 4,
   parameter logic [7:0] KEY_FIRST  = 8'hA5,
   parameter logic [7:0] KEY_SECOND = 8'h5A,
   localparam int BUF_BYTES = CS_BYTES + USR_BYTES,
   localparam int BIW = $clog2(BUF_BYTES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         host_addr,
   input  logic [DATA_W-1:0]         host_wdata,
   input  logic                      host_wr,
   input  logic                      host_rd,
   output logic [DATA_W-1:0]         host_rdata,
   input  logic                      dev_rx_load,
   input  logic [BUF_BYTES*DATA_W-1:0] dev_rx_bytes,
   input  logic [BIW-1:0]            dev_tx_idx,
   output logic [DATA_W-1:0]         dev_tx_byte
);
   localparam int CIW = $clog2(CTRL_LAST);
   localparam int TIW = (TEST_BYTES > 1) ? $clog2(TEST_BYTES) : 1;

   if (CTRL_LAST < 2 || CTRL_LAST >= int'(KEY_ADDR)) begin : g_bad_ctrl
      $error("paged_regbank: CTRL_LAST out of range");
   end
   if (BUF_BYTES < 2 || BUF_BYTES > int'(KEY_ADDR)) begin : g_bad_buf
      $error("paged_regbank: buffer size out of range");
   end
   if (TEST_BYTES < 1 || TEST_BYTES > int'(KEY_ADDR)) begin : g_bad_test
      $error("paged_regbank: TEST_BYTES out of range");
   end
   if (KEY_FIRST == KEY_SECOND) begin : g_bad_key
      $error("paged_regbank: unlock key bytes must differ");
   end

   page_e page_q;
   logic  unlocked;

   logic sel_hit;
   logic ctrl_hit, buf_hit, test_hit;
   logic [ADDR_W-1:0] ctrl_off;
   assign sel_hit  = (host_addr == SEL_ADDR);
   assign ctrl_off = host_addr - ADDR_W'(1);
   assign ctrl_hit = (host_addr != '0) && (host_addr <= ADDR_W'(CTRL_LAST));
   assign buf_hit  = (host_addr < ADDR_W'(BUF_BYTES));
   assign test_hit = unlocked && (host_addr < ADDR_W'(TEST_BYTES));

   // page register
   always_ff @(posedge clk) begin
      if (!rst_n)                 page_q <= PG_CTRL;
      else if (host_wr && sel_hit) page_q <= page_e'(host_wdata[1:0]);
   end

   regbank_unlock #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_unlock (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_wr     (host_wr),
      .key_wr     (host_wr && page_q == PG_CTRL && host_addr == KEY_ADDR),
      .wdata      (host_wdata),
      .unlocked_o (unlocked)
   );

   logic [CTRL_LAST*DATA_W-1:0]  ctrl_q;
   logic [BUF_BYTES*DATA_W-1:0]  rx_q, tx_q;
   logic [TEST_BYTES*DATA_W-1:0] test_q;

   regbank_store #(.N(CTRL_LAST), .HOST_WR(1'b1), .DEV_LOAD(1'b0)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_wr && page_q == PG_CTRL && ctrl_hit),
      .wr_idx(CIW'(ctrl_off)), .wr_data(host_wdata),
      .load_en(1'b0), .load_bytes('0), .bytes_o(ctrl_q));

   regbank_store #(.N(BUF_BYTES), .HOST_WR(1'b0), .DEV_LOAD(1'b1)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .wr_en(1'b0), .wr_idx(BIW'(host_addr)), .wr_data(host_wdata),
      .load_en(dev_rx_load), .load_bytes(dev_rx_bytes), .bytes_o(rx_q));

   regbank_store #(.N(BUF_BYTES), .HOST_WR(1'b1), .DEV_LOAD(1'b0)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_wr && page_q == PG_TX && buf_hit),
      .wr_idx(BIW'(host_addr)), .wr_data(host_wdata),
      .load_en(1'b0), .load_bytes('0), .bytes_o(tx_q));

   regbank_store #(.N(TEST_BYTES), .HOST_WR(1'b1), .DEV_LOAD(1'b0)) u_test (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_wr && page_q == PG_TEST && test_hit),
      .wr_idx(TIW'(host_addr)), .wr_data(host_wdata),
      .load_en(1'b0), .load_bytes('0), .bytes_o(test_q));

   // host read selection
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (sel_hit) begin
         rd_mux = DATA_W'(page_q);
      end else begin
         unique case (page_q)
            PG_CTRL: if (ctrl_hit) rd_mux = ctrl_q[CIW'(ctrl_off)*DATA_W +: DATA_W];
            PG_RX:   if (buf_hit)  rd_mux = rx_q[BIW'(host_addr)*DATA_W +: DATA_W];
            PG_TX:   if (buf_hit)  rd_mux = tx_q[BIW'(host_addr)*DATA_W +: DATA_W];
            PG_TEST: if (test_hit) rd_mux = test_q[TIW'(host_addr)*DATA_W +: DATA_W];
            default: rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       host_rdata <= '0;
      else if (host_rd) host_rdata <= rd_mux;
   end

   assign dev_tx_byte = (dev_tx_idx < BIW'(BUF_BYTES)) ?
                        tx_q[dev_tx_idx*DATA_W +: DATA_W] : '0;

   // R1: the page register takes the low two bits of a select write
   assert_page_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && sel_hit) |=> (page_q == page_e'($past(host_wdata[1:0]))));

   // R3: read data holds between read strobes
   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata));

   // R9: locked test page reads zero away from the select address
   assert_locked_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && page_q == PG_TEST && !unlocked && !sel_hit) |=> host_rdata == '0);

   // R4: reserved page-0 addresses read zero
   assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && page_q == PG_CTRL && !ctrl_hit && !sel_hit) |=> host_rdata == '0);
endmodule

// File: tb/paged_regbank_tb.sv
module paged_regbank_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_rdata;
   logic        dev_rx_load = 1'b0;
   logic [NB*8-1:0] dev_rx_bytes = '0;
   logic [5:0]  dev_tx_idx = '0;
   logic [7:0]  dev_tx_byte;

   always #(CLK_PERIOD/2) clk = ~clk;

   paged_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
      .dev_rx_load(dev_rx_load), .dev_rx_bytes(dev_rx_bytes),
      .dev_tx_idx(dev_tx_idx), .dev_tx_byte(dev_tx_byte));

   // behavioural reference model
   int   checks = 0, fails = 0;
   byte  m_ctrl [128];
   byte  m_rx [NB];
   byte  m_tx [NB];
   byte  m_test [4];
   int   m_page = 0;
   int   m_key = 0;
   bit   m_open = 0;
   logic [7:0] exp_rd = '0;
   string cur_tag = "R2";
   string exp_tag = "R2";

   function automatic logic [7:0] m_read(int a);
      if (a == 'h7F) return 8'(m_page);
      case (m_page)
         0: return (a >= 1 && a <= 'h33) ? m_ctrl[a] : 8'h00;
         1: return (a < NB) ? m_rx[a] : 8'h00;
         2: return (a < NB) ? m_tx[a] : 8'h00;
         default: return (m_open && a < 4) ? m_test[a] : 8'h00;
      endcase
   endfunction

   task automatic m_write(int a, logic [7:0] d);
      if (!m_open) begin
         if (m_page == 0 && a == 'h7E && m_key == 0 && d == 8'hA5) m_key = 1;
         else if (m_page == 0 && a == 'h7E && m_key == 1 && d == 8'h5A) m_open = 1;
         else m_key = 0;
      end
      if (a == 'h7F) m_page = int'(d[1:0]);
      else if (m_page == 0 && a >= 1 && a <= 'h33) m_ctrl[a] = d;
      else if (m_page == 2 && a < NB) m_tx[a] = d;
      else if (m_page == 3 && m_open && a < 4) m_test[a] = d;
   endtask

   initial begin
      foreach (m_ctrl[i]) m_ctrl[i] = 0;
      foreach (m_rx[i]) m_rx[i] = 0;
      foreach (m_tx[i]) m_tx[i] = 0;
      foreach (m_test[i]) m_test[i] = 0;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (host_rd) begin
            exp_rd = m_read(int'(host_addr));
            exp_tag = cur_tag;
         end else begin
            exp_tag = "R3";
         end
         if (host_wr) m_write(int'(host_addr), host_wdata);
         if (dev_rx_load)
            for (int i = 0; i < NB; i++) m_rx[i] = dev_rx_bytes[i*8 +: 8];
      end
   end

   always @(negedge clk) begin
      checks++;
      if (host_rdata !== exp_rd) begin
         fails++;
         $display("FAIL %s host_rdata actual=%h expected=%h", exp_tag, host_rdata, exp_rd);
      end
      checks++;
      if (dev_tx_byte !== m_tx[dev_tx_idx]) begin
         fails++;
         $display("FAIL R7 dev_tx_byte idx=%0d actual=%h expected=%h",
                  dev_tx_idx, dev_tx_byte, m_tx[dev_tx_idx]);
      end
   end

   task automatic wr(int a, logic [7:0] d, string tag);
      @(negedge clk);
      cur_tag = tag; host_addr = 7'(a); host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(int a, string tag);
      @(negedge clk);
      cur_tag = tag; host_addr = 7'(a); host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic load_rx(int seed);
      @(negedge clk);
      for (int i = 0; i < NB; i++) dev_rx_bytes[i*8 +: 8] = 8'(seed * 7 + i * 3);
      dev_rx_load = 1'b1;
      @(negedge clk);
      dev_rx_load = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 reset state
      rd('h7F, "R2"); rd('h01, "R2"); rd('h33, "R2");
      // R4 control bytes and reserved addresses
      wr('h01, 8'h11, "R4"); wr('h33, 8'h33, "R4"); wr('h00, 8'hEE, "R4");
      wr('h34, 8'hEE, "R4"); wr('h50, 8'hEE, "R4");
      rd('h01, "R4"); rd('h33, "R4"); rd('h00, "R4"); rd('h34, "R4"); rd('h7E, "R4");
      // R3 read and write same cycle returns old data
      @(negedge clk);
      cur_tag = "R3"; host_addr = 7'h01; host_wdata = 8'h99; host_wr = 1'b1; host_rd = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      repeat (3) @(negedge clk);
      rd('h01, "R3");
      // R1 page select with low bits only
      wr('h7F, 8'h05, "R1"); rd('h7F, "R1");
      // R5, R6 receive buffer
      wr('h7F, 8'h01, "R1");
      load_rx(1);
      rd(0, "R5"); rd(23, "R5"); rd(24, "R5"); rd(47, "R5");
      wr(5, 8'h77, "R5"); rd(5, "R5");
      @(negedge clk);
      for (int i = 0; i < NB; i++) dev_rx_bytes[i*8 +: 8] = 8'hC3;
      repeat (2) @(negedge clk);
      rd(5, "R6"); rd(40, "R6");
      load_rx(9); rd(5, "R6"); rd(40, "R6");
      rd(48, "R10"); rd('h7F, "R1");
      // R7 transmit buffer
      wr('h7F, 8'h02, "R1");
      for (int i = 0; i < NB; i += 5) wr(i, 8'(8'h40 + i), "R7");
      wr(47, 8'hF7, "R7"); wr(60, 8'hAB, "R10");
      rd(0, "R7"); rd(45, "R7"); rd(47, "R7"); rd(60, "R10");
      for (int i = 0; i < NB; i++) begin
         @(negedge clk); dev_tx_idx = 6'(i);
      end
      // R9 locked test page
      wr('h7F, 8'h03, "R1"); rd('h7F, "R1");
      wr(0, 8'h12, "R9"); rd(0, "R9"); rd(3, "R9");
      // R8 broken sequences
      wr('h7F, 8'h00, "R1");
      wr('h7E, 8'hA5, "R8"); wr('h02, 8'h00, "R8"); wr('h7E, 8'h5A, "R8");
      wr('h7E, 8'hA5, "R8"); wr('h7E, 8'hA5, "R8"); wr('h7E, 8'h5A, "R8");
      wr('h7F, 8'h03, "R8"); wr(1, 8'h34, "R8"); rd(1, "R8");
      // R8 correct sequence
      wr('h7F, 8'h00, "R8");
      wr('h7E, 8'hA5, "R8"); wr('h7E, 8'h5A, "R8");
      wr('h7F, 8'h03, "R8");
      wr(0, 8'hD0, "R9"); wr(3, 8'hD3, "R9"); wr(4, 8'hD4, "R10");
      rd(0, "R9"); rd(3, "R9"); rd(4, "R10");
      wr('h7E, 8'h00, "R8"); rd(0, "R8");
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule